// File: doc/BRIEF.md
# Serial NOR Flash Command Engine

This block is a byte-level model of a serial NOR flash slave that speaks the common 25-series opcode set. A host-side shifter hands it one byte per transfer while chip select is low and receives one response byte back for every byte taken. The engine decodes the opcode and collects a three-byte address. It then serves streaming reads, page programs, three sizes of region erase, whole-array erase, status and identification reads, and the setting or clearing of the write enable latch. The contents live in a small on-chip array sized by parameters. Bit-level shifting, real program and erase timing, and a busy flag are not modelled.

Both byte paths use valid/ready. An incoming byte is taken on a clock edge where `rx_valid`, `rx_ready` and a low `cs_n` coincide. Each taken byte loads one response into `tx_data` and raises `tx_valid` on the next cycle. The response is held until `tx_ready` is seen high, and `rx_ready` stays low while an unread response is pending. `rx_ready` is also low while an erase fill runs, which includes the fill of the whole array to 0xFF that follows reset. A producer must therefore hold its byte until the handshake completes. `cs_n` is a plain level and never stalls.

Top module: `spi_nor_engine`

## Requirements
- R1: Every byte taken yields exactly one response byte on the next cycle (`tx_valid` high). The response is held stable while `tx_ready` is low, and no new byte is taken while it waits. The response is 0x00 whenever no data is being returned.
- R2: A high `cs_n` returns the engine to idle and abandons any partly received command. The first byte of the next frame is decoded as an opcode.
- R3: The three address bytes form a 24-bit address, most significant byte first. The array index is the address modulo the array size, SECTOR_BYTES*NUM_SECTORS (1024 by default).
- R4: Page program (0x02) stores the bitwise AND of the old and the new byte when OVERWRITE is 0 (the default). When OVERWRITE is 1 it stores the new byte directly.
- R5: During page program the index advances by one after each data byte and wraps within its PAGE_BYTES-aligned page (32 bytes by default).
- R6: An erase sets every byte of its aligned region to 0xFF. The region is SMALL_BYTES (64) for 0x20, MID_BYTES (128) for 0x52, SECTOR_BYTES (256) for 0xD8 and the whole array for 0xC7. While the fill runs, `rx_ready` is low.
- R7: Opcode 0x20 is ignored unless SMALL_EN is set, and 0x52 is ignored unless MID_EN is set (defaults 1 and 0). An ignored erase leaves both the array and the write enable latch unchanged.
- R8: Program and every erase have no effect on the array while the write enable latch is clear.
- R9: 0x06 sets the write enable latch and 0x04 clears it. Status read (0x05) returns the latch in bit 1, with all other bits 0, so the value is 0x02 or 0x00. The latch clears when `cs_n` rises after a frame that programmed a byte or started an erase.
- R10: Read (0x03) returns the byte at the index, then advances the index by one per byte, wrapping from the last byte of the array to index 0.
- R11: Identification read (0x9F) returns ID_CODE high byte first (default A1 B2 C3). It then returns the two bytes of EXT_ID, high byte first (default 4D 5E), only when EXT_ID is nonzero. After that the engine is idle.
- R12: An opcode outside the set above is ignored: the engine stays idle, answers 0x00 and decodes the next byte as an opcode.
- R13: During reset `tx_valid` and `rx_ready` are 0. After reset the engine fills the array with 0xFF for DEPTH cycles, keeping `rx_ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low; high ends a frame |
| rx_valid | input | 1 | Incoming byte valid |
| rx_ready | output | 1 | Engine can take a byte |
| rx_data | input | 8 | Incoming command, address or data byte |
| tx_valid | output | 1 | Response byte valid |
| tx_ready | input | 1 | Consumer takes the response byte |
| tx_data | output | 8 | Response byte |

## Verification
The hardest case to reach from the ports is the set of effects that are invisible in the response stream. These are an ignored erase, a program or erase refused for lack of the write enable latch, and a partial command aborted by chip select. None of them changes the byte returned at the time. The stimulus therefore first plants known non-0xFF data inside and outside each erase region, and sets the latch where needed. It then issues the operation and reads the array and the status byte back in later frames. The abort case sets the latch first, so a status of 0x02 after the aborted frame shows that the next opcode was decoded from idle. Bytes left over in the address phase would have answered 0x00.

// File: rtl/flash_pkg.sv
package flash_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARG,
    ST_PROG,
    ST_STREAM,
    ST_RESP
  } eng_state_t;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_RDID  = 8'h9F;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_SMALL = 8'h20;
  localparam logic [7:0] OP_MID   = 8'h52;
  localparam logic [7:0] OP_SECT  = 8'hD8;
  localparam logic [7:0] OP_CHIP  = 8'hC7;
endpackage

// File: rtl/flash_array.sv
module flash_array #(
  parameter int DEPTH     = 1024,
  parameter bit OVERWRITE = 1'b0,
  localparam int AW       = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          fill_req,
  input  logic [AW-1:0] fill_base,
  input  logic [AW:0]   fill_len,
  output logic          fill_busy
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] fill_ptr;
  logic [AW:0]   fill_left;
  logic [7:0]    new_byte;

  assign fill_busy = (fill_left != '0);
  assign rd_data   = mem[rd_addr];

  generate
    if (OVERWRITE) begin : g_direct
      assign new_byte = wr_data;
    end else begin : g_and
      assign new_byte = mem[wr_addr] & wr_data;
    end
  endgenerate

  // Fill sequencer: one byte per cycle; reset starts a whole-array fill.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_ptr  <= '0;
      fill_left <= (AW+1)'(DEPTH);
    end else if (fill_busy) begin
      fill_ptr  <= fill_ptr + 1'b1;
      fill_left <= fill_left - 1'b1;
    end else if (fill_req) begin
      fill_ptr  <= fill_base;
      fill_left <= fill_len;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_busy) begin
      mem[fill_ptr] <= 8'hFF;
    end else if (wr_en) begin
      mem[wr_addr] <= new_byte;
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_pkg::*;
#(
  parameter int          DEPTH        = 1024,
  parameter int          PAGE_BYTES   = 32,
  parameter int          SECTOR_BYTES = 256,
  parameter int          SMALL_BYTES  = 64,
  parameter int          MID_BYTES    = 128,
  parameter bit          SMALL_EN     = 1'b1,
  parameter bit          MID_EN       = 1'b0,
  parameter logic [23:0] ID_CODE      = 24'hA1B2C3,
  parameter logic [15:0] EXT_ID       = 16'h4D5E,
  localparam int         AW           = $clog2(DEPTH),
  localparam int         PW           = $clog2(PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          accept,
  input  logic [7:0]    rx_byte,
  output logic [7:0]    rsp_byte,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          fill_req,
  output logic [AW-1:0] fill_base,
  output logic [AW:0]   fill_len,
  output logic          wel,
  output eng_state_t    state
);
  localparam logic [2:0] ID_LAST = (EXT_ID != 16'h0) ? 3'd4 : 3'd2;

  logic [7:0]    cmd;
  logic [1:0]    arg_cnt;
  logic [AW-1:0] ptr;
  logic [2:0]    rsp_idx;
  logic [2:0]    rsp_last;
  logic          wel_drop;
  logic [AW-1:0] next_idx;
  logic          last_arg;

  assign next_idx = AW'({ptr, rx_byte});
  assign last_arg = accept && (state == ST_ARG) && (arg_cnt == 2'd2);
  assign mem_addr = ptr;
  assign wr_en    = accept && (state == ST_PROG) && wel;
  assign wr_addr  = ptr;
  assign wr_data  = rx_byte;

  always_comb begin
    fill_req = 1'b0;
    fill_len = '0;
    if (accept && (state == ST_IDLE) && (rx_byte == OP_CHIP) && wel) begin
      fill_req = 1'b1;
      fill_len = (AW+1)'(DEPTH);
    end else if (last_arg && wel) begin
      case (cmd)
        OP_SECT:  begin fill_req = 1'b1;     fill_len = (AW+1)'(SECTOR_BYTES); end
        OP_SMALL: begin fill_req = SMALL_EN; fill_len = (AW+1)'(SMALL_BYTES);  end
        OP_MID:   begin fill_req = MID_EN;   fill_len = (AW+1)'(MID_BYTES);    end
        default:  ;
      endcase
    end
    fill_base = (state == ST_ARG) ? (next_idx & ~AW'(fill_len - 1'b1)) : '0;
  end

  always_comb begin
    rsp_byte = 8'h00;
    case (state)
      ST_STREAM: rsp_byte = mem_rdata;
      ST_RESP: begin
        if (cmd == OP_RDSR) begin
          rsp_byte = {6'b0, wel, 1'b0};
        end else begin
          case (rsp_idx)
            3'd0:    rsp_byte = ID_CODE[23:16];
            3'd1:    rsp_byte = ID_CODE[15:8];
            3'd2:    rsp_byte = ID_CODE[7:0];
            3'd3:    rsp_byte = EXT_ID[15:8];
            3'd4:    rsp_byte = EXT_ID[7:0];
            default: rsp_byte = 8'h00;
          endcase
        end
      end
      default: rsp_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cmd      <= 8'h00;
      arg_cnt  <= 2'd0;
      ptr      <= '0;
      rsp_idx  <= 3'd0;
      rsp_last <= 3'd0;
      wel      <= 1'b0;
      wel_drop <= 1'b0;
    end else if (cs_n) begin
      state   <= ST_IDLE;
      arg_cnt <= 2'd0;
      if (wel_drop) begin
        wel      <= 1'b0;
        wel_drop <= 1'b0;
      end
    end else if (accept) begin
      case (state)
        ST_IDLE: begin
          cmd <= rx_byte;
          case (rx_byte)
            OP_WREN: wel <= 1'b1;
            OP_WRDI: wel <= 1'b0;
            OP_RDSR: begin state <= ST_RESP; rsp_idx <= 3'd0; rsp_last <= 3'd0;    end
            OP_RDID: begin state <= ST_RESP; rsp_idx <= 3'd0; rsp_last <= ID_LAST; end
            OP_READ, OP_PROG, OP_SECT, OP_SMALL, OP_MID: begin
              state   <= ST_ARG;
              arg_cnt <= 2'd0;
            end
            OP_CHIP: if (wel) wel_drop <= 1'b1;
            default: ;
          endcase
        end
        ST_ARG: begin
          ptr     <= next_idx;
          arg_cnt <= arg_cnt + 2'd1;
          if (arg_cnt == 2'd2) begin
            if (cmd == OP_READ)      state <= ST_STREAM;
            else if (cmd == OP_PROG) state <= ST_PROG;
            else                     state <= ST_IDLE;
            if (fill_req) wel_drop <= 1'b1;
          end
        end
        ST_PROG: begin
          if (wel) wel_drop <= 1'b1;
          ptr <= {ptr[AW-1:PW], ptr[PW-1:0] + 1'b1};
        end
        ST_STREAM: ptr <= ptr + 1'b1;
        ST_RESP: begin
          if (rsp_idx == rsp_last) state <= ST_IDLE;
          else rsp_idx <= rsp_idx + 3'd1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_nor_engine.sv
module spi_nor_engine
  import flash_pkg::*;
#(
  parameter int          SECTOR_BYTES = 256,
  parameter int          NUM_SECTORS  = 4,
  parameter int          PAGE_BYTES   = 32,
  parameter int          SMALL_BYTES  = 64,
  parameter int          MID_BYTES    = 128,
  parameter bit          SMALL_EN     = 1'b1,
  parameter bit          MID_EN       = 1'b0,
  parameter bit          OVERWRITE    = 1'b0,
  parameter logic [23:0] ID_CODE      = 24'hA1B2C3,
  parameter logic [15:0] EXT_ID       = 16'h4D5E
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rx_valid,
  output logic       rx_ready,
  input  logic [7:0] rx_data,
  output logic       tx_valid,
  input  logic       tx_ready,
  output logic [7:0] tx_data
);
  localparam int DEPTH = SECTOR_BYTES * NUM_SECTORS;
  localparam int AW    = $clog2(DEPTH);

  logic          accept;
  logic [7:0]    rsp_byte;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_rdata;
  logic          mem_wr_en;
  logic [AW-1:0] mem_wr_addr;
  logic [7:0]    mem_wr_data;
  logic          fill_req;
  logic [AW-1:0] fill_base;
  logic [AW:0]   fill_len;
  logic          fill_busy;
  logic          wel;
  eng_state_t    state;

  assign rx_ready = !fill_busy && (!tx_valid || tx_ready);
  assign accept   = rx_valid && rx_ready && !cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= 8'h00;
    end else if (accept) begin
      tx_valid <= 1'b1;
      tx_data  <= rsp_byte;
    end else if (tx_ready) begin
      tx_valid <= 1'b0;
    end
  end

  flash_cmd_ctrl #(
    .DEPTH(DEPTH), .PAGE_BYTES(PAGE_BYTES), .SECTOR_BYTES(SECTOR_BYTES),
    .SMALL_BYTES(SMALL_BYTES), .MID_BYTES(MID_BYTES), .SMALL_EN(SMALL_EN),
    .MID_EN(MID_EN), .ID_CODE(ID_CODE), .EXT_ID(EXT_ID)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .accept(accept), .rx_byte(rx_data),
    .rsp_byte(rsp_byte), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .wr_en(mem_wr_en), .wr_addr(mem_wr_addr), .wr_data(mem_wr_data),
    .fill_req(fill_req), .fill_base(fill_base), .fill_len(fill_len),
    .wel(wel), .state(state)
  );

  flash_array #(.DEPTH(DEPTH), .OVERWRITE(OVERWRITE)) u_array (
    .clk(clk), .rst_n(rst_n), .rd_addr(mem_addr), .rd_data(mem_rdata),
    .wr_en(mem_wr_en), .wr_addr(mem_wr_addr), .wr_data(mem_wr_data),
    .fill_req(fill_req), .fill_base(fill_base), .fill_len(fill_len),
    .fill_busy(fill_busy)
  );
endmodule

// File: rtl/spi_nor_engine_chk.sv
module spi_nor_engine_chk
  import flash_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       accept,
  input logic       rx_ready,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       fill_busy,
  input logic       mem_wr_en,
  input logic       fill_req,
  input logic       wel,
  input eng_state_t state
);
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) accept |=> tx_valid); // R1
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n) (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R1
  AST_CS_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n) cs_n |=> (state == ST_IDLE)); // R2
  AST_FILL_STALLS: assert property (@(posedge clk) disable iff (!rst_n) fill_busy |-> !rx_ready); // R13
  AST_PROG_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n) mem_wr_en |-> wel); // R8
  AST_ERASE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n) fill_req |-> wel); // R8
  AST_WEL_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $fell(wel) |-> ($past(cs_n) || $past(accept))); // R9
endmodule

bind spi_nor_engine spi_nor_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .accept(accept), .rx_ready(rx_ready),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .fill_busy(fill_busy), .mem_wr_en(mem_wr_en), .fill_req(fill_req),
  .wel(wel), .state(state)
);

// File: tb/spi_nor_engine_tb.sv
module spi_nor_engine_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       tx_ready = 1'b1;
  logic       rx_ready;
  logic       tx_valid;
  logic [7:0] tx_data;
  int         n_chk = 0;
  int         n_fail = 0;

  always #5 clk = ~clk;

  spi_nor_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
  );

  // Entry 24'hRE_DD_XX: R = requirement, E = raise cs after, DD = byte sent, XX = expected reply.
  localparam logic [23:0] VEC [58] = '{
    // R9 status with latch clear
    24'h9_0_05_00, 24'h9_1_FF_00,
    // R8 program refused without latch, then read back 0xFF
    24'h8_0_02_00, 24'h8_0_00_00, 24'h8_0_00_00, 24'h8_0_10_00, 24'h8_1_A5_00,
    24'h8_0_03_00, 24'h8_0_00_00, 24'h8_0_00_00, 24'h8_0_10_00, 24'h8_1_00_FF,
    // R9 set latch, status 0x02
    24'h9_1_06_00, 24'h9_0_05_00, 24'h9_1_00_02,
    // R5 program three bytes at 0x1E; third wraps to 0x00; then R9 latch cleared
    24'h5_0_02_00, 24'h5_0_00_00, 24'h5_0_00_00, 24'h5_0_1E_00, 24'h5_0_0F_00,
    24'h5_0_F0_00, 24'h5_1_3C_00, 24'h9_0_05_00, 24'h9_1_00_00,
    // R10 streaming read from 0x1E
    24'hA_0_03_00, 24'hA_0_00_00, 24'hA_0_00_00, 24'hA_0_1E_00, 24'hA_0_00_0F,
    24'hA_0_00_F0, 24'hA_1_00_FF,
    // R5 wrapped byte landed at index 0
    24'h5_0_03_00, 24'h5_0_00_00, 24'h5_0_00_00, 24'h5_0_00_00, 24'h5_1_00_3C,
    // R3 address 0x1E0000 maps to index 0 (MSB first)
    24'h3_0_03_00, 24'h3_0_1E_00, 24'h3_0_00_00, 24'h3_0_00_00, 24'h3_1_00_3C,
    // R10 read at 0xFC03FF wraps to index 0
    24'hA_0_03_00, 24'hA_0_FC_00, 24'hA_0_03_00, 24'hA_0_FF_00, 24'hA_0_00_FF,
    24'hA_1_00_3C,
    // R11 identification, then idle
    24'hB_0_9F_00, 24'hB_0_00_A1, 24'hB_0_00_B2, 24'hB_0_00_C3, 24'hB_0_00_4D,
    24'hB_0_00_5E, 24'hB_1_00_00,
    // R12 unknown opcode, next byte decoded as status
    24'h9_1_06_00, 24'hC_0_AB_00, 24'hC_0_05_00, 24'hC_1_00_02
  };

  task automatic check(input logic [8:0] act, input logic [8:0] exp, input int req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] d, input logic [7:0] exp, input int req);
    @(negedge clk);
    cs_n = 1'b0;
    rx_data = d;
    rx_valid = 1'b1;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
    check({tx_valid, tx_data}, {1'b1, exp}, req, "reply");
  endtask

  task automatic endf();
    @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic frame4(input logic [7:0] op, input logic [15:0] a, input logic [7:0] d,
                        input logic [7:0] exp, input int req);
    xfer(op, 8'h00, req);
    xfer(8'h00, 8'h00, req);
    xfer(a[15:8], 8'h00, req);
    xfer(a[7:0], 8'h00, req);
    xfer(d, exp, req);
    endf();
  endtask

  task automatic erase(input logic [7:0] op, input logic [15:0] a, input int req);
    xfer(op, 8'h00, req);
    xfer(8'h00, 8'h00, req);
    xfer(a[15:8], 8'h00, req);
    xfer(a[7:0], 8'h00, req);
    endf();
  endtask

  task automatic one(input logic [7:0] op, input int req);
    xfer(op, 8'h00, req);
    endf();
  endtask

  task automatic status(input logic [7:0] exp, input int req);
    xfer(8'h05, 8'h00, req);
    xfer(8'h00, exp, req);
    endf();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual running expected done");
    finish_run();
  end

  initial begin
    // R13 reset state and init fill
    repeat (3) @(negedge clk);
    check({7'b0, tx_valid, rx_ready}, 9'h000, 13, "reset outputs");
    rst_n = 1'b1;
    repeat (500) @(negedge clk);
    check({8'b0, rx_ready}, 9'h000, 13, "stall during init fill");
    while (!rx_ready) @(negedge clk);

    for (int i = 0; i < 58; i++) begin
      xfer(VEC[i][15:8], VEC[i][7:0], int'(VEC[i][23:20]));
      if (VEC[i][19:16] != 4'h0) endf();
    end

    // R4 AND programming: 0x0F & 0xF5 = 0x05 (latch set by table)
    frame4(8'h02, 16'h001E, 8'hF5, 8'h00, 4);
    frame4(8'h03, 16'h001E, 8'h00, 8'h05, 4);
    one(8'h06, 9);
    frame4(8'h02, 16'h0050, 8'h11, 8'h00, 4);

    // R7 mid erase ignored: data and latch kept
    one(8'h06, 9);
    erase(8'h52, 16'h0000, 7);
    frame4(8'h03, 16'h0050, 8'h00, 8'h11, 7);
    status(8'h02, 7);
    one(8'h04, 9);
    status(8'h00, 9);

    // R8 erase refused without latch
    erase(8'h20, 16'h0010, 8);
    frame4(8'h03, 16'h001E, 8'h00, 8'h05, 8);

    // R6 small erase clears 0x00..0x3F only; R9 latch dropped
    one(8'h06, 9);
    erase(8'h20, 16'h0010, 6);
    frame4(8'h03, 16'h001E, 8'h00, 8'hFF, 6);
    frame4(8'h03, 16'h0050, 8'h00, 8'h11, 6);
    status(8'h00, 9);

    // R6 sector erase clears 0x00..0xFF
    one(8'h06, 9);
    erase(8'hD8, 16'h0060, 6);
    frame4(8'h03, 16'h0050, 8'h00, 8'hFF, 6);

    // R6 chip erase
    one(8'h06, 9);
    frame4(8'h02, 16'h0200, 8'h00, 8'h00, 4);
    frame4(8'h03, 16'h0200, 8'h00, 8'h00, 4);
    one(8'h06, 9);
    one(8'hC7, 6);
    frame4(8'h03, 16'h0200, 8'h00, 8'hFF, 6);

    // R2 abort partial read; next frame decodes status from idle
    one(8'h06, 9);
    xfer(8'h03, 8'h00, 2);
    xfer(8'h00, 8'h00, 2);
    endf();
    status(8'h02, 2);

    // R1 back-pressure on the response
    tx_ready = 1'b0;
    xfer(8'h05, 8'h00, 1);
    @(negedge clk);
    check({7'b0, tx_valid, rx_ready}, 9'h002, 1, "held reply blocks input");
    tx_ready = 1'b1;
    @(negedge clk);
    check({8'b0, tx_valid}, 9'h000, 1, "reply released");
    xfer(8'h00, 8'h02, 1);
    endf();

    finish_run();
  end
endmodule